// File: doc/BRIEF.md
# Regulator Configuration I2C Target

This block is the serial configuration port of a voltage-regulator controller. It oversamples the two-wire bus lines with the system clock, cleans them, and detects START, repeated START and STOP. It answers a single 7-bit target address and never holds the clock line low. Its only output onto the bus is an open-drain data-line enable.

A controller writes the setpoint, ceiling, slew and mode registers with a pointer byte followed by a data byte. Any number of pointer/data pairs may follow one address phase, in any register order. A read sets the pointer with a write phase, then uses a repeated START and the read address to get one byte. The register values drive the regulator logic directly. A status byte combines live undervoltage and overvoltage levels, a ceiling-violation flag, and two latched fault flags that clear once the status byte has been read out.

Top module: `vrc_cfg_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit address {0111, DEV_BITS[1:0], addr_sel_i}, for both write (R/W=0) and read (R/W=1). Every other address, including the all-zero general call, gets no acknowledge.
- R2: In a write, the first byte after the address is the register pointer and the second is data. The data takes effect at the SCL falling edge that ends its acknowledge clock. The writable registers are: pointer 0x02 ceiling (7 bits, vid_max_o), 0x05 mode (bits 7, 3, 2, 1, 0 writable, cfg_o), 0x06 slew (4 bits, slew_o) and 0x07 setpoint (7 bits, vid_o).
- R3: After one address phase, any number of pointer/data pairs are accepted and applied, in any register order, until STOP.
- R4: A read (write phase with pointer, repeated START, read address) returns the selected register MSB first. The pointer does not advance.
- R5: Writes to read-only (0x00, 0x04) or unmapped pointers are acknowledged and change nothing. Unmapped pointers and unused bits read as 0.
- R6: Status at pointer 0x04: bit 5 thermal and bit 2 overcurrent latch on their event inputs and clear after a status byte is fully shifted out. Bit 4 (undervoltage) and bit 3 (overvoltage) follow their inputs. Bit 1 is 1 when setpoint > ceiling. Bits 7, 6 and 0 are 0.
- R7: A STOP at any bit position ends the transfer, and a partly received data byte is discarded.
- R8: A STOP in the same SCL high period as the START before it is ignored, and the transfer continues with the address byte.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transfer.
- R10: After reset, the registers hold their parameter defaults, SDA is released, and the SDA enable changes to drive only while SCL is low.
- R11: Pointer 0x00 reads ID_VALUE (default 0x03).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 1 | Address LSB select |
| therm_evt_i | input | 1 | Thermal shutdown event |
| ocur_evt_i | input | 1 | Overcurrent event |
| uv_i | input | 1 | Live undervoltage level |
| ov_i | input | 1 | Live overvoltage level |
| vid_max_o | output | 7 | Setpoint ceiling |
| cfg_o | output | 8 | Mode register |
| slew_o | output | 4 | Slew code |
| vid_o | output | 7 | Setpoint code |

## Verification
The hardest condition to reach is a STOP that falls inside the same SCL high period as a START. A correct master never makes it. The bench builds it by hand: it drops SDA, raises SDA again while SCL stays high, and then sends a whole write without a fresh START. A write that lands proves the STOP was ignored. Filter rejection is reached the same way. Sub-threshold pulses are put on SCL and SDA in the middle of a data byte, and the check is that the stored value comes out intact.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RDAT_ACK, ST_WAIT
  } bus_st_t;

  localparam logic [7:0] PTR_ID   = 8'h00;
  localparam logic [7:0] PTR_VMAX = 8'h02;
  localparam logic [7:0] PTR_STAT = 8'h04;
  localparam logic [7:0] PTR_CFG  = 8'h05;
  localparam logic [7:0] PTR_SLEW = 8'h06;
  localparam logic [7:0] PTR_VID  = 8'h07;
  localparam logic [7:0] CFG_WMASK = 8'h8F;
endpackage

// File: rtl/vrc_line_filter.sv
module vrc_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          clean_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      clean_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == clean_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        clean_q <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/vrc_i2c_engine.sv
module vrc_i2c_engine
  import vrc_pkg::*;
#(
  parameter logic [1:0] DEV_BITS = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       addr_sel_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic [7:0] ptr_o,
  output logic       wr_stb_o,
  output logic [7:0] wr_data_o,
  output logic       rd_done_o
);
  bus_st_t    state_q;
  logic       scl_q, sda_q;
  logic       start_hi_q;
  logic [3:0] bitcnt_q;
  logic [7:0] shreg_q;
  logic [7:0] ptr_q;
  logic       rw_q, mack_q;
  logic       sda_oe_q, wr_stb_q, rd_done_q;

  logic [6:0] my_addr;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign my_addr   = {4'b0111, DEV_BITS, addr_sel_i};
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      start_hi_q <= 1'b0;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      wr_stb_q   <= 1'b0;
      rd_done_q  <= 1'b0;
    end else begin
      scl_q     <= scl_f;
      sda_q     <= sda_f;
      wr_stb_q  <= 1'b0;
      rd_done_q <= 1'b0;
      if (scl_fall) start_hi_q <= 1'b0;

      if (start_det) begin
        state_q    <= ST_ADDR;
        bitcnt_q   <= '0;
        sda_oe_q   <= 1'b0;
        start_hi_q <= 1'b1;
      end else if (stop_det && !start_hi_q) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise) begin
              shreg_q  <= {shreg_q[6:0], sda_f};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              bitcnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shreg_q[7:1] == my_addr) begin
                  sda_oe_q <= 1'b1;
                  rw_q     <= shreg_q[0];
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else if (state_q == ST_PTR) begin
                ptr_q    <= shreg_q;
                sda_oe_q <= 1'b1;
                state_q  <= ST_PTR_ACK;
              end else begin
                sda_oe_q <= 1'b1;
                state_q  <= ST_WDAT_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (rw_q) begin
                shreg_q  <= rd_data_i;
                sda_oe_q <= ~rd_data_i[7];
                state_q  <= ST_RDAT;
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK: begin
            if (scl_fall) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_WDAT;
            end
          end
          ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe_q <= 1'b0;
              wr_stb_q <= 1'b1;
              state_q  <= ST_PTR;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bitcnt_q == 4'd7) begin
                sda_oe_q  <= 1'b0;
                rd_done_q <= 1'b1;
                bitcnt_q  <= '0;
                state_q   <= ST_RDAT_ACK;
              end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
                shreg_q  <= {shreg_q[6:0], 1'b0};
                sda_oe_q <= ~shreg_q[6];
              end
            end
          end
          ST_RDAT_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                shreg_q  <= rd_data_i;
                sda_oe_q <= ~rd_data_i[7];
                state_q  <= ST_RDAT;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign ptr_o     = ptr_q;
  assign wr_stb_o  = wr_stb_q;
  assign wr_data_o = shreg_q;
  assign rd_done_o = rd_done_q;

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_q) |-> !scl_f);
  a_r2_wr_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_stb_q |=> !wr_stb_q);
  a_r4_rd_done_single: assert property (@(posedge clk) disable iff (rst)
    rd_done_q |=> !rd_done_q);
  a_r7_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_hi_q && !start_det) |=> (state_q == ST_IDLE) && !sda_oe_q);
endmodule

// File: rtl/vrc_reg_bank.sv
module vrc_reg_bank
  import vrc_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h03,
  parameter logic [6:0] RST_VMAX = 7'h4E,
  parameter logic [7:0] RST_CFG  = 8'h00,
  parameter logic [3:0] RST_SLEW = 4'h0,
  parameter logic [6:0] RST_VID  = 7'h2E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb_i,
  input  logic [7:0] ptr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_done_i,
  input  logic       therm_evt_i,
  input  logic       ocur_evt_i,
  input  logic       uv_i,
  input  logic       ov_i,
  output logic [7:0] rd_data_o,
  output logic [6:0] vid_max_o,
  output logic [7:0] cfg_o,
  output logic [3:0] slew_o,
  output logic [6:0] vid_o
);
  logic [6:0] vmax_q, vid_q;
  logic [7:0] cfg_q;
  logic [3:0] slew_q;
  logic       therm_q, ocur_q;
  logic       stat_clr;
  logic [7:0] status;

  assign stat_clr = rd_done_i && (ptr_i == PTR_STAT);
  assign status   = {2'b00, therm_q, uv_i, ov_i, ocur_q, (vid_q > vmax_q), 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      vmax_q  <= RST_VMAX;
      cfg_q   <= RST_CFG & CFG_WMASK;
      slew_q  <= RST_SLEW;
      vid_q   <= RST_VID;
      therm_q <= 1'b0;
      ocur_q  <= 1'b0;
    end else begin
      if (wr_stb_i) begin
        case (ptr_i)
          PTR_VMAX: vmax_q <= wr_data_i[6:0];
          PTR_CFG:  cfg_q  <= wr_data_i & CFG_WMASK;
          PTR_SLEW: slew_q <= wr_data_i[3:0];
          PTR_VID:  vid_q  <= wr_data_i[6:0];
          default: ;
        endcase
      end
      if (therm_evt_i)   therm_q <= 1'b1;
      else if (stat_clr) therm_q <= 1'b0;
      if (ocur_evt_i)    ocur_q  <= 1'b1;
      else if (stat_clr) ocur_q  <= 1'b0;
    end
  end

  always_comb begin
    case (ptr_i)
      PTR_ID:   rd_data_o = ID_VALUE;
      PTR_VMAX: rd_data_o = {1'b0, vmax_q};
      PTR_STAT: rd_data_o = status;
      PTR_CFG:  rd_data_o = cfg_q;
      PTR_SLEW: rd_data_o = {4'b0000, slew_q};
      PTR_VID:  rd_data_o = {1'b0, vid_q};
      default:  rd_data_o = 8'h00;
    endcase
  end

  assign vid_max_o = vmax_q;
  assign cfg_o     = cfg_q;
  assign slew_o    = slew_q;
  assign vid_o     = vid_q;

  a_r6_therm_sticky: assert property (@(posedge clk) disable iff (rst)
    (therm_q && !stat_clr) |=> therm_q);
  a_r6_ocur_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !ocur_evt_i) |=> !ocur_q);
  a_r2_vid_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_i |=> $stable(vid_q));
  a_r2_vmax_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_i |=> $stable(vmax_q));
endmodule

// File: rtl/vrc_cfg_i2c_target.sv
module vrc_cfg_i2c_target #(
  parameter logic [1:0] DEV_BITS = 2'b00,
  parameter int         FILT_LEN = 4,
  parameter logic [7:0] ID_VALUE = 8'h03,
  parameter logic [6:0] RST_VMAX = 7'h4E,
  parameter logic [7:0] RST_CFG  = 8'h00,
  parameter logic [3:0] RST_SLEW = 4'h0,
  parameter logic [6:0] RST_VID  = 7'h2E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_sel_i,
  input  logic       therm_evt_i,
  input  logic       ocur_evt_i,
  input  logic       uv_i,
  input  logic       ov_i,
  output logic [6:0] vid_max_o,
  output logic [7:0] cfg_o,
  output logic [3:0] slew_o,
  output logic [6:0] vid_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic [7:0] ptr, wr_data, rd_data;
  logic       wr_stb, rd_done;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    vrc_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (raw_lines[g]),
      .clean_o (clean_lines[g])
    );
  end

  vrc_i2c_engine #(.DEV_BITS(DEV_BITS)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .scl_f      (clean_lines[0]),
    .sda_f      (clean_lines[1]),
    .addr_sel_i (addr_sel_i),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (ptr),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .rd_done_o  (rd_done)
  );

  vrc_reg_bank #(
    .ID_VALUE (ID_VALUE),
    .RST_VMAX (RST_VMAX),
    .RST_CFG  (RST_CFG),
    .RST_SLEW (RST_SLEW),
    .RST_VID  (RST_VID)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_stb_i    (wr_stb),
    .ptr_i       (ptr),
    .wr_data_i   (wr_data),
    .rd_done_i   (rd_done),
    .therm_evt_i (therm_evt_i),
    .ocur_evt_i  (ocur_evt_i),
    .uv_i        (uv_i),
    .ov_i        (ov_i),
    .rd_data_o   (rd_data),
    .vid_max_o   (vid_max_o),
    .cfg_o       (cfg_o),
    .slew_o      (slew_o),
    .vid_o       (vid_o)
  );
endmodule

// File: tb/vrc_cfg_i2c_target_tb.sv
module vrc_cfg_i2c_target_tb;
  localparam int Q = 6;
  localparam int FILT = 4;
  localparam logic [6:0] TGT = {4'b0111, 2'b00, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b1;
  logic therm = 1'b0, ocur = 1'b0, uv = 1'b0, ov = 1'b0;
  logic sda_oe, sda_line;
  logic [6:0] vid_max, vid;
  logic [7:0] cfg;
  logic [3:0] slew;

  int total = 0, bad = 0;
  bit done = 0;

  logic [6:0] m_vmax = 7'h4E, m_vid = 7'h2E;
  logic [7:0] m_cfg = 8'h00;
  logic [3:0] m_slew = 4'h0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  vrc_cfg_i2c_target #(.FILT_LEN(FILT)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .therm_evt_i(therm), .ocur_evt_i(ocur),
    .uv_i(uv), .ov_i(ov), .vid_max_o(vid_max), .cfg_o(cfg),
    .slew_o(slew), .vid_o(vid)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b, input int glitch);
    tick(Q); sda_m = b; tick(Q); scl_m = 1'b1;
    if (glitch == 1) begin
      tick(7); scl_m = 1'b0; tick(FILT-1); scl_m = 1'b1; tick(2*Q-7-(FILT-1));
    end else if (glitch == 2) begin
      tick(7); sda_m = ~b; tick(FILT-1); sda_m = b; tick(2*Q-7-(FILT-1));
    end else begin
      tick(2*Q);
    end
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit ack);
    for (int i = 7; i >= 0; i--)
      send_bit(b[i], gl ? ((i == 4) ? 1 : ((i == 2) ? 2 : 0)) : 0);
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      d[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte({TGT, 1'b0}, 0, a0);
    send_byte(p, 0, a1);
    send_byte(d, 0, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_reg(input logic [7:0] p, output logic [7:0] d);
    bit a;
    bus_start();
    send_byte({TGT, 1'b0}, 0, a);
    send_byte(p, 0, a);
    bus_start();
    send_byte({TGT, 1'b1}, 0, a);
    recv_byte(d);
    bus_stop();
  endtask

  function automatic logic [7:0] stat_exp(input logic t, input logic o);
    return {2'b00, t, uv, ov, o, (m_vid > m_vmax), 1'b0};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit ok, a;
    logic [7:0] ptrs [4];
    logic [7:0] masks [4];
    ptrs[0] = 8'h02; ptrs[1] = 8'h05; ptrs[2] = 8'h06; ptrs[3] = 8'h07;
    masks[0] = 8'h7F; masks[1] = 8'h8F; masks[2] = 8'h0F; masks[3] = 8'h7F;

    tick(5); rst = 1'b0; tick(5);
    // R10 reset state
    check("R10 sda_oe", {7'd0, sda_oe}, 8'h00);
    check("R10 vid_max", {1'b0, vid_max}, 8'h4E);
    check("R10 cfg", cfg, 8'h00);
    check("R10 slew", {4'd0, slew}, 8'h00);
    check("R10 vid", {1'b0, vid}, 8'h2E);

    // R11 identity
    rd_reg(8'h00, d);
    check("R11 id", d, 8'h03);

    // R1 address sweep, write direction
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      send_byte({7'(ad), 1'b0}, 0, a);
      bus_stop();
      check("R1 addr ack", {7'd0, a}, {7'd0, (7'(ad) == TGT)});
    end
    bus_start(); send_byte(8'h00, 0, a); bus_stop();
    check("R1 general call", {7'd0, a}, 8'h00);
    bus_start(); send_byte({TGT, 1'b1}, 0, a); recv_byte(d); bus_stop();
    check("R1 read addr ack", {7'd0, a}, 8'h01);
    addr_sel = 1'b0;
    bus_start(); send_byte({TGT, 1'b0}, 0, a); bus_stop();
    check("R1 pin low old addr", {7'd0, a}, 8'h00);
    bus_start(); send_byte({TGT[6:1], 1'b0, 1'b0}, 0, a); bus_stop();
    check("R1 pin low new addr", {7'd0, a}, 8'h01);
    addr_sel = 1'b1;

    // R2 / R4 write and read sweep
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] v, e;
        v = 8'(i * 8'h25 + 8'h5A + r * 8'h11);
        e = v & masks[r];
        wr_reg(ptrs[r], v, ok);
        case (r)
          0: begin m_vmax = e[6:0]; check("R2 vid_max port", {1'b0, vid_max}, e); end
          1: begin m_cfg = e;       check("R2 cfg port", cfg, e); end
          2: begin m_slew = e[3:0]; check("R2 slew port", {4'd0, slew}, e); end
          default: begin m_vid = e[6:0]; check("R2 vid port", {1'b0, vid}, e); end
        endcase
        rd_reg(ptrs[r], d);
        check("R4 readback", d, e);
      end
    end

    // R3 multi-pair write in mixed order
    bus_start();
    send_byte({TGT, 1'b0}, 0, a);
    send_byte(8'h07, 0, a); send_byte(8'h11, 0, a);
    send_byte(8'h06, 0, a); send_byte(8'h05, 0, a);
    send_byte(8'h05, 0, a); send_byte(8'hFF, 0, a);
    send_byte(8'h02, 0, a); send_byte(8'h7F, 0, a);
    bus_stop();
    m_vid = 7'h11; m_slew = 4'h5; m_cfg = 8'h8F; m_vmax = 7'h7F;
    check("R3 vid", {1'b0, vid}, 8'h11);
    check("R3 slew", {4'd0, slew}, 8'h05);
    check("R3 cfg", cfg, 8'h8F);
    check("R3 vid_max", {1'b0, vid_max}, 8'h7F);

    // R5 read-only and unmapped
    wr_reg(8'h00, 8'hA5, ok);  check("R5 ro ack", {7'd0, ok}, 8'h01);
    wr_reg(8'h04, 8'hFF, ok);  check("R5 status ro ack", {7'd0, ok}, 8'h01);
    wr_reg(8'h01, 8'h33, ok);  check("R5 unmapped ack", {7'd0, ok}, 8'h01);
    wr_reg(8'h2B, 8'h3C, ok);
    rd_reg(8'h00, d);          check("R5 id kept", d, 8'h03);
    rd_reg(8'h01, d);          check("R5 unmapped reads 0", d, 8'h00);
    rd_reg(8'h2B, d);          check("R5 unmapped 2B reads 0", d, 8'h00);
    check("R5 ports kept", {1'b0, vid}, 8'h11);
    check("R5 cfg kept", cfg, 8'h8F);

    // R6 status
    rd_reg(8'h04, d); check("R6 status clean", d, stat_exp(0, 0));
    therm = 1'b1; tick(1); therm = 1'b0;
    rd_reg(8'h04, d); check("R6 thermal latched", d, stat_exp(1, 0));
    rd_reg(8'h04, d); check("R6 thermal cleared", d, stat_exp(0, 0));
    ocur = 1'b1; tick(1); ocur = 1'b0;
    therm = 1'b1; tick(1); therm = 1'b0;
    tick(50);
    rd_reg(8'h04, d); check("R6 both latched", d, stat_exp(1, 1));
    rd_reg(8'h04, d); check("R6 both cleared", d, stat_exp(0, 0));
    uv = 1'b1;
    rd_reg(8'h04, d); check("R6 uv live", d, stat_exp(0, 0));
    uv = 1'b0; ov = 1'b1;
    rd_reg(8'h04, d); check("R6 ov live", d, stat_exp(0, 0));
    ov = 1'b0;
    wr_reg(8'h02, 8'h20, ok); m_vmax = 7'h20;
    wr_reg(8'h07, 8'h21, ok); m_vid = 7'h21;
    rd_reg(8'h04, d); check("R6 vmerr set", d, 8'h02);
    wr_reg(8'h07, 8'h20, ok); m_vid = 7'h20;
    rd_reg(8'h04, d); check("R6 vmerr equal clear", d, 8'h00);

    // R7 STOP mid data byte
    bus_start();
    send_byte({TGT, 1'b0}, 0, a);
    send_byte(8'h07, 0, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 0);
    bus_stop();
    check("R7 partial discarded", {1'b0, vid}, 8'h20);
    wr_reg(8'h07, 8'h33, ok);
    check("R7 next write ok", {1'b0, vid}, 8'h33);

    // R8 STOP in same high as START
    tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b0;
    send_byte({TGT, 1'b0}, 0, a);
    check("R8 addr ack after ignored stop", {7'd0, a}, 8'h01);
    send_byte(8'h07, 0, a);
    send_byte(8'h4C, 0, a);
    bus_stop();
    check("R8 write landed", {1'b0, vid}, 8'h4C);

    // R9 glitches inside a data byte
    bus_start();
    send_byte({TGT, 1'b0}, 0, a);
    send_byte(8'h06, 0, a);
    send_byte(8'h0A, 1, a);
    bus_stop();
    check("R9 glitch ack", {7'd0, a}, 8'h01);
    check("R9 slew intact", {4'd0, slew}, 8'h0A);
    check("R10 sda released idle", {7'd0, sda_oe}, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule